// File: doc/BRIEF.md
# Parallel Flash Programming Port

This block models the parallel programming side of a 4 KB on-chip flash array. A programmer presents a 12-bit byte address, an 8-bit data byte and a 4-bit operation code. It then strikes an active-low program strobe while a level that stands in for the high-voltage supply is asserted.

Byte writes and lock-bit writes time themselves with a counter once struck. During the write the ready/busy pin reads low. A byte write can only clear bits, so a byte that is not blank needs a chip erase before it can take arbitrary data. A chip erase is started only by a strobe held low long enough in erase mode. It refills the whole array with ones and clears the lock bits. Verify reads and signature reads come back on the data output one clock after the address and mode are presented.

All pins are plain level signals and there is no stream handshake. No back-pressure exists: ready/busy is advisory, and a strobe that arrives while the block is busy is dropped rather than queued. Time constants derive from a clocks-per-millisecond parameter.

Top module: `flash_prog_port`

## Requirements
- R1: After reset, `rdy_bsy` is 1 and `dout` is 00h.
- R2: A falling edge of `prog_n` sampled with `mode` = 4'h1 and `hv_en` = 1 starts a byte write. `rdy_bsy` is 0 for exactly WRITE_CLKS = CLK_PER_MS*3/2 clock cycles, starting the cycle after the sampling edge.
- R3: A byte write stores the bitwise AND of the old byte and `din`, so bits can only go from 1 to 0. After an erase, a read returns the written byte.
- R4: While a byte write is busy, `mode` = 4'h2 makes `dout` show the complement of bit 7 of the byte being written in bit 7, with bits 6..0 zero.
- R5: When idle with lock bits 1 and 2 clear, `mode` = 4'h2 returns the byte at `addr` on `dout` one clock later.
- R6: Strobes in modes 4'h3, 4'h4 and 4'h5 program lock bits 1, 2 and 3 with the R2 timing. With lock bit 1 or 2 set, reads in mode 4'h2 return 00h. Lock bit 3 alone leaves reads intact.
- R7: In mode 4'h6 with `hv_en` = 1, a `prog_n` low for ERASE_CLKS = 10*CLK_PER_MS consecutive clock samples starts an erase. The erase holds `rdy_bsy` low for 2^ADDR_W cycles, sets every byte to FFh and clears all three lock bits. A shorter low pulse has no effect.
- R8: Mode 4'h7 returns 1Eh at 030h and 51h at 031h. At 032h it returns FFh when VPP12 = 1 or 05h when VPP12 = 0. It returns 00h at any other address.
- R9: Strobes with an unlisted mode code, or with `hv_en` = 0, leave `rdy_bsy` high and the array unchanged. Modes other than 4'h2 and 4'h7 drive `dout` to 00h.
- R10: A strobe that arrives while a write is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data byte to program |
| mode | input | 4 | Operation code |
| prog_n | input | 1 | Active-low program strobe |
| hv_en | input | 1 | Programming supply present |
| dout | output | 8 | Read, polling or signature byte |
| rdy_bsy | output | 1 | 1 = ready, 0 = busy |

## Verification
The hardest situations to reach are the strobe that lands inside a running write and the erase pulse that falls one sample short of its threshold. Both depend on the exact clock at which `prog_n` moves relative to the internal counters. The bench places those edges at counted negedges. It then reads the target bytes back to prove nothing changed. Random address and data writes accumulate AND-merged contents in a bench model. Polling reads are inserted mid-write on a random subset of those writes.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  typedef enum logic [3:0] {
    MD_IDLE  = 4'h0,
    MD_WRITE = 4'h1,
    MD_READ  = 4'h2,
    MD_LOCK1 = 4'h3,
    MD_LOCK2 = 4'h4,
    MD_LOCK3 = 4'h5,
    MD_ERASE = 4'h6,
    MD_SIG   = 4'h7
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROG  = 2'd1,
    ST_SWEEP = 2'd2
  } state_e;

  localparam logic [7:0] SIG_MAKER = 8'h1E;
  localparam logic [7:0] SIG_PART  = 8'h51;
endpackage

// File: rtl/fpp_timer.sv
module fpp_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         zero
);
  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R2
endmodule

// File: rtl/fpp_array.sv
module fpp_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              merge_en,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [DATA_W-1:0] rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (fill_en)       mem[wa] <= '1;
    else if (merge_en) mem[wa] <= mem[wa] & wd;
  end

  assign rd = mem[ra];

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(merge_en && fill_en)); // R7
endmodule

// File: rtl/fpp_ctrl.sv
module fpp_ctrl
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int CLK_PER_MS = 12000,
  parameter bit VPP12      = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic [3:0]        mode,
  input  logic              prog_n,
  input  logic              hv_en,
  input  logic [7:0]        arr_rd,
  output logic              arr_merge,
  output logic              arr_fill,
  output logic [ADDR_W-1:0] arr_wa,
  output logic [7:0]        arr_wd,
  output logic [7:0]        dout,
  output logic              rdy_bsy
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int WRITE_CLKS = (CLK_PER_MS * 3) / 2;
  localparam int ERASE_CLKS = CLK_PER_MS * 10;
  localparam int TW         = $clog2(WRITE_CLKS + 1);
  localparam int EW         = $clog2(ERASE_CLKS + 1);
  localparam logic [ADDR_W-1:0] LAST    = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W-1:0] A_MAKER = ADDR_W'(12'h030);
  localparam logic [ADDR_W-1:0] A_PART  = ADDR_W'(12'h031);
  localparam logic [ADDR_W-1:0] A_VOLT  = ADDR_W'(12'h032);

  state_e            st;
  logic              prog_q, fall;
  logic [3:0]        op;
  logic [ADDR_W-1:0] wa, sa;
  logic [7:0]        wd, dout_nx, sig_volt;
  logic [2:0]        locks;
  logic              armed;
  logic [EW-1:0]     lo_cnt;
  logic [TW-1:0]     tmr_cnt;
  logic              tmr_zero;
  logic              is_prog_mode, start_prog, arm_erase, hold_ok, erase_go, commit, locked;

  generate
    if (VPP12) begin : g_volt12
      assign sig_volt = 8'hFF;
    end else begin : g_volt5
      assign sig_volt = 8'h05;
    end
  endgenerate

  assign fall         = prog_q & ~prog_n;
  assign is_prog_mode = (mode == MD_WRITE) || (mode == MD_LOCK1) ||
                        (mode == MD_LOCK2) || (mode == MD_LOCK3);
  assign start_prog   = (st == ST_IDLE) && hv_en && fall && is_prog_mode;
  assign arm_erase    = (st == ST_IDLE) && hv_en && fall && (mode == MD_ERASE);
  assign hold_ok      = (st == ST_IDLE) && armed && hv_en && !prog_n && (mode == MD_ERASE);
  assign erase_go     = hold_ok && (lo_cnt == EW'(ERASE_CLKS - 1));
  assign commit       = (st == ST_PROG) && tmr_zero;
  assign locked       = locks[0] | locks[1];

  fpp_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_prog),
    .load_val (TW'(WRITE_CLKS - 1)),
    .cnt      (tmr_cnt),
    .zero     (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      prog_q <= 1'b1;
      op     <= MD_IDLE;
      wa     <= '0;
      wd     <= '0;
      sa     <= '0;
      locks  <= '0;
      armed  <= 1'b0;
      lo_cnt <= '0;
    end else begin
      prog_q <= prog_n;
      unique case (st)
        ST_IDLE: begin
          if (start_prog) begin
            op <= mode;
            wa <= addr;
            wd <= din;
            st <= ST_PROG;
          end
          if (arm_erase) begin
            armed  <= 1'b1;
            lo_cnt <= EW'(1);
          end else if (erase_go) begin
            armed  <= 1'b0;
            lo_cnt <= '0;
            sa     <= '0;
            st     <= ST_SWEEP;
          end else if (hold_ok) begin
            lo_cnt <= lo_cnt + 1'b1;
          end else begin
            armed  <= 1'b0;
            lo_cnt <= '0;
          end
        end
        ST_PROG: begin
          if (commit) begin
            if (op == MD_LOCK1) locks[0] <= 1'b1;
            if (op == MD_LOCK2) locks[1] <= 1'b1;
            if (op == MD_LOCK3) locks[2] <= 1'b1;
            st <= ST_IDLE;
          end
        end
        ST_SWEEP: begin
          sa <= sa + 1'b1;
          if (sa == LAST) begin
            locks <= '0;
            st    <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dout_nx = 8'h00;
    if (st == ST_PROG && op == MD_WRITE && mode == MD_READ) begin
      dout_nx = {~wd[7], 7'h00};
    end else if (st == ST_IDLE && mode == MD_READ) begin
      dout_nx = locked ? 8'h00 : arr_rd;
    end else if (st == ST_IDLE && mode == MD_SIG) begin
      if (addr == A_MAKER)     dout_nx = SIG_MAKER;
      else if (addr == A_PART) dout_nx = SIG_PART;
      else if (addr == A_VOLT) dout_nx = sig_volt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dout <= 8'h00;
    else        dout <= dout_nx;
  end

  assign arr_merge = commit && (op == MD_WRITE);
  assign arr_fill  = (st == ST_SWEEP);
  assign arr_wa    = arr_fill ? sa : wa;
  assign arr_wd    = wd;
  assign rdy_bsy   = (st == ST_IDLE);

  AST_RDY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    start_prog |=> !rdy_bsy); // R2
  AST_POLL_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROG && op == MD_WRITE && mode == MD_READ) |=>
      (dout[6:0] == 7'h00 && dout[7] != $past(wd[7]))); // R4
  AST_LOCK_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && mode == MD_READ && locked) |=> (dout == 8'h00)); // R6
  AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SWEEP && sa != LAST) |=> (st == ST_SWEEP && sa == ADDR_W'($past(sa) + 1'b1))); // R7
  AST_ERASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SWEEP && sa == LAST) |=> (locks == 3'b000 && rdy_bsy)); // R7
  AST_NO_HV_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!hv_en && st == ST_IDLE) |=> (st == ST_IDLE)); // R9
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROG && !commit) |=> ($stable(wa) && $stable(wd) && st == ST_PROG)); // R10
endmodule

// File: rtl/flash_prog_port.sv
module flash_prog_port #(
  parameter int ADDR_W     = 12,
  parameter int CLK_PER_MS = 12000,
  parameter bit VPP12      = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic [3:0]        mode,
  input  logic              prog_n,
  input  logic              hv_en,
  output logic [7:0]        dout,
  output logic              rdy_bsy
);
  logic              arr_merge, arr_fill;
  logic [ADDR_W-1:0] arr_wa;
  logic [7:0]        arr_wd, arr_rd;

  fpp_ctrl #(
    .ADDR_W     (ADDR_W),
    .CLK_PER_MS (CLK_PER_MS),
    .VPP12      (VPP12)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .din       (din),
    .mode      (mode),
    .prog_n    (prog_n),
    .hv_en     (hv_en),
    .arr_rd    (arr_rd),
    .arr_merge (arr_merge),
    .arr_fill  (arr_fill),
    .arr_wa    (arr_wa),
    .arr_wd    (arr_wd),
    .dout      (dout),
    .rdy_bsy   (rdy_bsy)
  );

  fpp_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .merge_en (arr_merge),
    .fill_en  (arr_fill),
    .wa       (arr_wa),
    .wd       (arr_wd),
    .ra       (addr),
    .rd       (arr_rd)
  );
endmodule

// File: tb/flash_prog_port_bench.sv
`timescale 1ns/1ps
module flash_prog_port_bench;
  localparam int AW    = 12;
  localparam int DEPTH = 1 << AW;
  localparam int CPM   = 4;
  localparam int WR    = (CPM * 3) / 2;
  localparam int ER    = CPM * 10;
  localparam logic [3:0] C_IDLE = 4'h0, C_WRITE = 4'h1, C_READ = 4'h2, C_LK1 = 4'h3,
                         C_LK2 = 4'h4, C_LK3 = 4'h5, C_ERASE = 4'h6, C_SIG = 4'h7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [3:0] mode = C_IDLE;
  logic prog_n = 1'b1, hv_en = 1'b1;
  logic [7:0] dout;
  logic rdy_bsy;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];
  bit lk1 = 0, lk2 = 0;

  always #5 clk = ~clk;

  flash_prog_port #(.ADDR_W(AW), .CLK_PER_MS(CPM), .VPP12(1'b1)) u_flash_prog_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .mode(mode),
    .prog_n(prog_n), .hv_en(hv_en), .dout(dout), .rdy_bsy(rdy_bsy));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input int a);
    return (lk1 || lk2) ? 8'h00 : model[a];
  endfunction

  task automatic do_prog(input logic [3:0] md, input int a, input logic [7:0] d,
                         input bit poll, output int low);
    @(negedge clk); mode = md; addr = AW'(a); din = d; prog_n = 1'b0;
    @(negedge clk); prog_n = 1'b1; if (poll) mode = C_READ;
    low = 0;
    while (rdy_bsy == 1'b0 && low < 20000) begin
      if (poll && low == 1) chk("R4 polling byte", int'(dout), int'({~d[7], 7'h00}));
      low++;
      @(negedge clk);
    end
    mode = C_IDLE;
  endtask

  task automatic do_erase(input int samples, output int low);
    @(negedge clk); mode = C_ERASE; prog_n = 1'b0;
    repeat (samples) @(negedge clk);
    prog_n = 1'b1;
    low = 0;
    while (rdy_bsy == 1'b0 && low < 20000) begin
      low++;
      @(negedge clk);
    end
    mode = C_IDLE;
  endtask

  task automatic rd(input logic [3:0] md, input int a, output logic [7:0] v);
    @(negedge clk); mode = md; addr = AW'(a);
    @(negedge clk); v = dout; mode = C_IDLE;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int low;
    logic [7:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdy after reset", int'(rdy_bsy), 1);
    chk("R1 dout after reset", int'(dout), 0);

    do_erase(ER - 1, low);
    chk("R7 short erase pulse ignored", low, 0);
    do_erase(ER, low);
    chk("R7 erase busy length", low, DEPTH);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    for (int i = 0; i < 4; i++) begin
      int a = int'($urandom % DEPTH);
      rd(C_READ, a, v); chk("R7 erased byte", int'(v), 8'hFF);
    end

    do_prog(C_WRITE, 12'h123, 8'h0F, 1'b0, low);
    do_prog(C_WRITE, 12'h123, 8'hF0, 1'b0, low);
    model[12'h123] = 8'h00;
    rd(C_READ, 12'h123, v); chk("R3 AND merge", int'(v), 0);

    for (int i = 0; i < 30; i++) begin
      int a = int'($urandom % DEPTH);
      logic [7:0] d = 8'($urandom);
      do_prog(C_WRITE, a, d, (i % 3 == 0), low);
      chk("R2 write busy length", low, WR);
      model[a] = model[a] & d;
      rd(C_READ, a, v); chk("R3 written byte", int'(v), int'(model[a]));
      a = int'($urandom % DEPTH);
      rd(C_READ, a, v); chk("R5 verify read", int'(v), int'(exp_read(a)));
    end
    do_prog(C_WRITE, 12'h200, 8'h80, 1'b1, low); model[12'h200] &= 8'h80;
    do_prog(C_WRITE, 12'h201, 8'h7F, 1'b1, low); model[12'h201] &= 8'h7F;

    rd(C_SIG, 12'h030, v); chk("R8 maker byte", int'(v), 8'h1E);
    rd(C_SIG, 12'h031, v); chk("R8 part byte", int'(v), 8'h51);
    rd(C_SIG, 12'h032, v); chk("R8 volt byte", int'(v), 8'hFF);
    rd(C_SIG, 12'h033, v); chk("R8 other address", int'(v), 0);

    do_prog(4'hA, 12'h300, 8'h00, 1'b0, low);
    chk("R9 unknown mode no busy", low, 0);
    rd(C_READ, 12'h300, v); chk("R9 unknown mode no change", int'(v), int'(model[12'h300]));
    hv_en = 1'b0;
    do_prog(C_WRITE, 12'h301, 8'h00, 1'b0, low);
    hv_en = 1'b1;
    chk("R9 no supply no busy", low, 0);
    rd(C_READ, 12'h301, v); chk("R9 no supply no change", int'(v), int'(model[12'h301]));
    @(negedge clk); mode = C_LK2; addr = 12'h301;
    @(negedge clk); chk("R9 non-read mode dout", int'(dout), 0); mode = C_IDLE;

    @(negedge clk); mode = C_WRITE; addr = 12'h100; din = 8'h3C; prog_n = 1'b0;
    @(negedge clk); prog_n = 1'b1;
    @(negedge clk); addr = 12'h101; din = 8'h00; prog_n = 1'b0;
    @(negedge clk); prog_n = 1'b1;
    while (rdy_bsy == 1'b0) @(negedge clk);
    mode = C_IDLE;
    model[12'h100] &= 8'h3C;
    rd(C_READ, 12'h101, v); chk("R10 strobe while busy dropped", int'(v), int'(model[12'h101]));
    rd(C_READ, 12'h100, v); chk("R10 first write kept", int'(v), int'(model[12'h100]));

    do_prog(C_LK3, 0, 8'h00, 1'b0, low);
    chk("R6 lock busy length", low, WR);
    rd(C_READ, 12'h200, v); chk("R6 lock3 keeps reads", int'(v), int'(model[12'h200]));
    do_prog(C_LK1, 0, 8'h00, 1'b0, low); lk1 = 1;
    rd(C_READ, 12'h200, v); chk("R6 lock1 hides", int'(v), int'(exp_read(12'h200)));
    do_erase(ER, low);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    lk1 = 0;
    rd(C_READ, 12'h200, v); chk("R7 erase clears lock", int'(v), 8'hFF);
    do_prog(C_LK2, 0, 8'h00, 1'b0, low); lk2 = 1;
    rd(C_READ, 12'h200, v); chk("R6 lock2 hides", int'(v), int'(exp_read(12'h200)));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule